// File: doc/BRIEF.md
# Cascaded Masked Interrupt Aggregator

The block gathers 96 interrupt sources into three 32-bit groups: a primary-low group (sources 0 to 31), a primary-high group (32 to 63) and a port group (64 to 95). Each group has a cause register and a mask register. Primary causes follow their level sources, sampled every clock. Port causes are sticky: an event sets the bit, and it stays set until software clears it. Four bits of the primary-high cause register do not come from sources. Instead, each one summarises one byte of the unmasked port causes, so the port group cascades into the primary-high group.

A CPU reads a vector register over a small 32-bit register bus. The vector holds the number of the selected pending source, or a spurious code. The search runs in a fixed order. It looks first at the primary-low group. It looks at the primary-high group only when the low group has no candidate. If a summary bit wins in the high group, the search moves into the port group. Within a group, the winner is the highest-numbered bit that is pending, enabled and eligible. When a vector read returns a port source, that port cause bit clears in the same cycle. A registered interrupt line tells the CPU that some eligible, unmasked primary source is pending.

Top module: `casc_irq_agg`

## Requirements
- R1: After reset all three masks read 0, the port cause reads 0, the vector reads the spurious code 0x7F, and `cpu_irq_o` is 0. While the masks are 0, no source affects the vector.
- R2: Only primary-low bits in 0x3DFFFFFE are eligible. Bits 0, 25, 30 and 31 are never selected, even when set and unmasked. The vector for a low winner equals the highest eligible unmasked pending bit number.
- R3: The primary-high group is searched only when no eligible unmasked low bit is pending. Only high bits in 0x0F000DB7 are eligible. A high winner below bit 24 gives the vector 32 plus the bit number.
- R4: High cause bits 24 to 27 read the OR of the unmasked port causes 8*(k-24) to 8*(k-24)+7. The high source inputs at those positions are ignored.
- R5: When a summary bit wins in the high group, the vector is 64 plus the highest pending unmasked port bit. If no such port bit exists, the vector is 0x7F.
- R6: A port event bit at 1 sets the matching port cause bit. A write to the port cause clears each bit written as 0 and leaves each bit written as 1 unchanged. An event in the same cycle as a clear keeps the bit set.
- R7: A vector read that returns a port source clears that port cause bit in the same cycle, unless an event for that bit arrives in the same cycle. A read that returns a primary source clears no port bit.
- R8: The vector is 0x7F when no eligible unmasked source is pending. Otherwise it lies in 0 to 95. It is read in bits 6:0 of the vector register, with bits 31:7 at 0.
- R9: `cpu_irq_o` is 1 exactly one clock after the cause and mask registers hold an eligible unmasked low or high bit. A source change reaches the cause register on the next edge, so it reaches `cpu_irq_o` two edges later.
- R10: Register word addresses are: 0 low cause (read-only), 1 low mask, 2 high cause (read-only), 3 high mask, 4 port cause, 5 port mask, 6 vector (read-only). Read data appears on `reg_rdata_o` the cycle after the request. Writes to read-only registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lo_src_i | input | 32 | Level sources of the primary-low group |
| hi_src_i | input | 32 | Level sources of the primary-high group (bits 27:24 unused) |
| port_evt_i | input | 32 | Port events, set the sticky port causes |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| cpu_irq_o | output | 1 | Registered CPU interrupt request |

## Verification
Two things can hit the same port cause bit in one edge. One is a new event. The other is a clear, either from a vector read that chose the bit or from a write-zero. The bench provokes both collisions by driving `port_evt_i` in the same cycle as the vector read or the clearing write. It then expects the returned vector to be computed from the old state, and the bit to read back as still set. The read-side clear is also tested where it must not happen, when a primary source wins the vector.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int unsigned GW     = 32;
  localparam int unsigned IW     = $clog2(GW);
  localparam int unsigned VW     = IW + 2;
  localparam int unsigned NSUM   = 4;
  localparam int unsigned SUM_LSB = 24;
  localparam int unsigned SPAN   = GW / NSUM;

  localparam logic [VW-1:0] VEC_SPUR = '1;
  localparam logic [IW-1:0] SUM_LSB_I = IW'(SUM_LSB);
  localparam logic [GW-1:0] SUM_FIELD = GW'({NSUM{1'b1}}) << SUM_LSB;

  typedef enum logic [2:0] {
    A_LO_CAUSE = 3'd0,
    A_LO_MASK  = 3'd1,
    A_HI_CAUSE = 3'd2,
    A_HI_MASK  = 3'd3,
    A_PT_CAUSE = 3'd4,
    A_PT_MASK  = 3'd5,
    A_VEC      = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // highest set bit wins: later iterations overwrite
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign hit_o = |req_i;
endmodule

// File: rtl/irq_port_bank.sv
module irq_port_bank
  import casc_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] evt_i,
  input  logic          wr_i,
  input  logic [GW-1:0] wdata_i,
  input  logic          vclr_i,
  input  logic [IW-1:0] vidx_i,
  output logic [GW-1:0] cause_o,
  output logic [NSUM-1:0] sum_o,
  input  logic [GW-1:0] mask_i
);
  logic [GW-1:0] cause_q, clr;
  logic [GW-1:0] pend;

  always_comb begin
    clr = '0;
    if (wr_i)   clr = clr | ~wdata_i;
    if (vclr_i) clr = clr | (GW'(1) << vidx_i);
  end

  // set dominates clear so a fresh event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr) | evt_i;
  end

  assign pend = cause_q & mask_i;

  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    assign sum_o[g] = |pend[g*SPAN +: SPAN];
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import casc_irq_pkg::*;
(
  input  logic [GW-1:0] lo_pend_i,
  input  logic [GW-1:0] hi_pend_i,
  input  logic [GW-1:0] pt_pend_i,
  output logic [VW-1:0] code_o,
  output logic          is_port_o,
  output logic [IW-1:0] port_idx_o
);
  logic          lo_hit, hi_hit, pt_hit;
  logic [IW-1:0] lo_idx, hi_idx, pt_idx;

  irq_prio_enc #(.W(GW)) u_lo (.req_i(lo_pend_i), .hit_o(lo_hit), .idx_o(lo_idx));
  irq_prio_enc #(.W(GW)) u_hi (.req_i(hi_pend_i), .hit_o(hi_hit), .idx_o(hi_idx));
  irq_prio_enc #(.W(GW)) u_pt (.req_i(pt_pend_i), .hit_o(pt_hit), .idx_o(pt_idx));

  always_comb begin
    code_o    = VEC_SPUR;
    is_port_o = 1'b0;
    if (lo_hit) begin
      code_o = {2'b00, lo_idx};
    end else if (hi_hit) begin
      if (hi_idx >= SUM_LSB_I) begin
        if (pt_hit) begin
          code_o    = {2'b10, pt_idx};
          is_port_o = 1'b1;
        end
      end else begin
        code_o = {2'b01, hi_idx};
      end
    end
  end

  assign port_idx_o = pt_idx;
endmodule

// File: rtl/casc_irq_agg.sv
module casc_irq_agg
  import casc_irq_pkg::*;
#(
  parameter logic [31:0] LO_ELIG = 32'h3DFF_FFFE,
  parameter logic [31:0] HI_ELIG = 32'h0F00_0DB7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] lo_src_i,
  input  logic [31:0] hi_src_i,
  input  logic [31:0] port_evt_i,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cpu_irq_o
);
  logic [GW-1:0] lo_cause_q, hi_src_q;
  logic [GW-1:0] lo_mask_q, hi_mask_q, pt_mask_q;
  logic [GW-1:0] hi_cause, pt_cause;
  logic [GW-1:0] lo_pend, hi_pend, pt_pend;
  logic [NSUM-1:0] sum;
  logic [VW-1:0] vec_code;
  logic          is_port;
  logic [IW-1:0] port_idx;
  logic          rd, wr, rd_vec, wr_pt_cause, main_any;
  logic [31:0]   rdata_q, rmux;
  logic          irq_q;
  reg_addr_e     addr;

  assign addr        = reg_addr_e'(reg_addr_i);
  assign rd          = reg_req_i && !reg_we_i;
  assign wr          = reg_req_i && reg_we_i;
  assign rd_vec      = rd && (addr == A_VEC);
  assign wr_pt_cause = wr && (addr == A_PT_CAUSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cause_q <= '0;
      hi_src_q   <= '0;
    end else begin
      lo_cause_q <= lo_src_i;
      hi_src_q   <= hi_src_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_mask_q <= '0;
      hi_mask_q <= '0;
      pt_mask_q <= '0;
    end else if (wr) begin
      case (addr)
        A_LO_MASK: lo_mask_q <= reg_wdata_i;
        A_HI_MASK: hi_mask_q <= reg_wdata_i;
        A_PT_MASK: pt_mask_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  irq_port_bank u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (port_evt_i),
    .wr_i    (wr_pt_cause),
    .wdata_i (reg_wdata_i),
    .vclr_i  (rd_vec && is_port),
    .vidx_i  (port_idx),
    .cause_o (pt_cause),
    .sum_o   (sum),
    .mask_i  (pt_mask_q)
  );

  // summary bits replace the source bits in the cascade field
  assign hi_cause = (hi_src_q & ~SUM_FIELD) | (GW'(sum) << SUM_LSB);

  assign lo_pend = lo_cause_q & lo_mask_q & LO_ELIG;
  assign hi_pend = hi_cause & hi_mask_q & HI_ELIG;
  assign pt_pend = pt_cause & pt_mask_q;
  assign main_any = (|lo_pend) || (|hi_pend);

  irq_vec_sel u_sel (
    .lo_pend_i  (lo_pend),
    .hi_pend_i  (hi_pend),
    .pt_pend_i  (pt_pend),
    .code_o     (vec_code),
    .is_port_o  (is_port),
    .port_idx_o (port_idx)
  );

  always_comb begin
    case (addr)
      A_LO_CAUSE: rmux = lo_cause_q;
      A_LO_MASK:  rmux = lo_mask_q;
      A_HI_CAUSE: rmux = hi_cause;
      A_HI_MASK:  rmux = hi_mask_q;
      A_PT_CAUSE: rmux = pt_cause;
      A_PT_MASK:  rmux = pt_mask_q;
      A_VEC:      rmux = 32'(vec_code);
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rmux;
      irq_q <= main_any;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign cpu_irq_o   = irq_q;
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk
  import casc_irq_pkg::*;
#(
  parameter logic [31:0] LO_ELIG = 32'h3DFF_FFFE
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_vec,
  input logic          is_port,
  input logic [IW-1:0] port_idx,
  input logic [GW-1:0] pt_cause,
  input logic [GW-1:0] port_evt,
  input logic [VW-1:0] vec_code,
  input logic [GW-1:0] lo_pend,
  input logic          main_any,
  input logic          cpu_irq
);
  // R7
  vec_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && is_port) |=> (!pt_cause[$past(port_idx)] || $past(port_evt[port_idx])));

  // R6
  evt_sets_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_evt) |=> ((pt_cause & $past(port_evt)) == $past(port_evt)));

  // R8
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_code < VW'(96)) || (vec_code == VEC_SPUR));

  // R2
  lo_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_code < VW'(32)) |-> LO_ELIG[vec_code[IW-1:0]]);

  // R3
  hi_after_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_code >= VW'(32) && vec_code < VW'(64)) |-> (lo_pend == '0));

  // R9
  irq_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cpu_irq == $past(main_any)));
endmodule

bind casc_irq_agg casc_irq_chk #(.LO_ELIG(LO_ELIG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_vec   (rd_vec),
  .is_port  (is_port),
  .port_idx (port_idx),
  .pt_cause (pt_cause),
  .port_evt (port_evt_i),
  .vec_code (vec_code),
  .lo_pend  (lo_pend),
  .main_any (main_any),
  .cpu_irq  (cpu_irq_o)
);

// File: tb/tb_casc_irq_agg.sv
module tb_casc_irq_agg;
  localparam time TCLK = 10ns;
  localparam logic [2:0] LOC = 3'd0, LOM = 3'd1, HIC = 3'd2, HIM = 3'd3,
                         PTC = 3'd4, PTM = 3'd5, VEC = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lo_src = '0, hi_src = '0, evt = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(TCLK/2) clk = ~clk;

  casc_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .lo_src_i(lo_src), .hi_src_i(hi_src),
    .port_evt_i(evt), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cpu_irq_o(irq)
  );

  // monitor: a read captured at a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= req && !we;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %08h expected %08h", t, rdata, e);
      end
    end
  end

  task automatic rd_evt(input logic [2:0] a, input logic [31:0] e,
                        input logic [31:0] ev, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; evt = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    rd_evt(a, e, 32'h0, t);
  endtask

  task automatic wr_evt(input logic [2:0] a, input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; evt = ev;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_evt(a, d, 32'h0);
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk); evt = ev;
    @(negedge clk); evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: cpu_irq got %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(LOM, 32'h0, "R1 lo mask");
    rd(HIM, 32'h0, "R1 hi mask");
    rd(PTM, 32'h0, "R1 port mask");
    rd(PTC, 32'h0, "R1 port cause");
    rd(VEC, 32'h7F, "R1 vector spurious");
    lo_src = 32'h4;
    rd(VEC, 32'h7F, "R1 masked source ignored");
    settle(); chk_irq(1'b0, "R1 masked irq");

    wr(LOM, 32'hFFFF_FFFF);
    wr(HIM, 32'hFFFF_FFFF);

    // R9 latency from source edge
    lo_src = '0; settle();
    chk_irq(1'b0, "R9 idle");
    @(negedge clk) lo_src = 32'h4;
    @(negedge clk) chk_irq(1'b0, "R9 one edge after source");
    @(negedge clk) chk_irq(1'b1, "R9 two edges after source");

    // R2 low group selection
    rd(VEC, 32'd2, "R2 single low bit");
    lo_src = 32'hC200_0001;
    rd(VEC, 32'h7F, "R2 reserved bits ignored");
    settle(); chk_irq(1'b0, "R2 reserved no irq");
    lo_src = 32'h2000_0010;
    rd(VEC, 32'd29, "R2 highest eligible");
    wr(LOM, 32'hDFFF_FFFF);
    rd(VEC, 32'd4, "R2 masked top bit");
    wr(LOM, 32'hFFFF_FFFF);

    // R3 high group
    lo_src = '0; hi_src = 32'h0000_0048;
    rd(VEC, 32'h7F, "R3 ineligible high bits");
    hi_src = 32'h0000_0850;
    rd(VEC, 32'd43, "R3 high winner");
    lo_src = 32'h4;
    rd(VEC, 32'd2, "R3 low beats high");
    lo_src = '0; hi_src = 32'hF000_0000;
    rd(VEC, 32'h7F, "R3 high reserved top");

    // R4 source bits in summary field ignored
    hi_src = 32'h0F00_0000;
    rd(HIC, 32'h0, "R4 summary field not from source");
    rd(VEC, 32'h7F, "R4 no port pending");
    hi_src = '0;

    // R10 read-only cause
    wr(LOC, 32'hFFFF_FFFF);
    rd(LOC, 32'h0, "R10 low cause read-only");
    lo_src = 32'h1234;
    rd(LOC, 32'h1234, "R10 low cause follows source");
    lo_src = '0;
    wr(VEC, 32'h0);
    rd(VEC, 32'h7F, "R10 vector write ignored");

    // R6 port latch, R4 summary, R5 port vector, R7 read clear
    pulse(32'h0000_0100);
    rd(PTC, 32'h0000_0100, "R6 event latched");
    rd(HIC, 32'h0, "R4 masked port no summary");
    rd(VEC, 32'h7F, "R5 masked port spurious");
    wr(PTM, 32'hFFFF_FFFF);
    rd(HIC, 32'h0200_0000, "R4 summary byte 1");
    chk_irq(1'b1, "R9 port via summary");
    rd(VEC, 32'd72, "R5 port vector");
    rd(PTC, 32'h0, "R7 read cleared port bit");
    pulse(32'h8000_0001);
    rd(HIC, 32'h0900_0000, "R4 summary bytes 0 and 3");
    rd(VEC, 32'd95, "R5 highest port first");
    rd(VEC, 32'd64, "R5 then lowest port");
    rd(VEC, 32'h7F, "R8 port drained");
    rd(PTC, 32'h0, "R7 all cleared");

    // R6 write-zero-to-clear
    pulse(32'h0000_00F0);
    wr(PTC, 32'hFFFF_FFDF);
    rd(PTC, 32'h0000_00D0, "R6 zero clears bit");
    wr(PTC, 32'hFFFF_FFFF);
    rd(PTC, 32'h0000_00D0, "R6 ones keep bits");

    // collisions: event vs read clear, event vs write clear
    rd_evt(VEC, 32'd71, 32'h0000_0080, "R7 vector with same-cycle event");
    rd(PTC, 32'h0000_00D0, "R7 event wins over read clear");
    wr_evt(PTC, 32'hFFFF_FFEF, 32'h0000_0010);
    rd(PTC, 32'h0000_00D0, "R6 event wins over write clear");

    // R7 primary winner leaves port alone
    lo_src = 32'h2;
    rd(VEC, 32'd1, "R7 low winner over port");
    rd(PTC, 32'h0000_00D0, "R7 low read keeps port");
    lo_src = '0;

    // R3 summary masked in high mask
    hi_src = 32'h0000_0800;
    wr(HIM, 32'h0000_0FFF);
    rd(VEC, 32'd43, "R3 summary masked high bit wins");
    rd(PTC, 32'h0000_00D0, "R7 high read keeps port");
    wr(HIM, 32'h0);
    settle(); chk_irq(1'b0, "R9 all high masked");

    settle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule